// File: doc/BRIEF.md
# Segmented Linear Address Generator

This unit turns an operand addressing request into a linear address in one registered step. A request carries an optional base register value, an optional index register value with a 2-bit scale code, a displacement with a size code, and a 16-bit segment selector. The effective offset is computed as base plus scaled index plus displacement, wrapping modulo 2^32. The selector picks one entry from a small on-chip descriptor cache. Each entry holds a segment base, a segment limit and the privilege level the segment allows. The linear address is the segment base plus the offset.

The request is rejected in three cases. The selector can point outside the populated cache. The requested privilege can be weaker than the segment allows. The offset can run past the limit. Only one fault code is reported, in a fixed priority order. The descriptor cache is filled through a simple write port, one entry per clock. Requests enter and results leave through valid/ready handshakes, with one register stage between them.

Top module: `seg_addr_gen`

## Requirements
- R1: The effective offset is base + scaled index + extended displacement, and the linear address is descriptor base + offset. All sums wrap modulo 2^32.
- R2: The scale code multiplies the index: code 00 gives x1, 01 gives x2, 10 gives x4, 11 gives x8.
- R3: The displacement size code works as follows. 00 means no displacement, and `in_disp` is ignored. 01 uses `in_disp[7:0]` sign-extended to 32 bits. 10 and 11 use all 32 bits of `in_disp`.
- R4: When `in_base_en` is low, the base contributes zero. When `in_idx_en` is low, the index contributes zero. This allows base-only, index-only and displacement-only requests.
- R5: The selector fields are: bits [15:3] hold the entry index, bit [2] picks the table (0 = global, 1 = local), and bits [1:0] hold the requested privilege level.
- R6: An index of 8 or more, or an entry never written since reset, gives fault code 01 (invalid selector).
- R7: A requested privilege level numerically greater than the entry's allowed level gives fault code 10 (privilege violation).
- R8: An offset strictly greater than the entry's limit gives fault code 11 (limit violation). An offset equal to the limit is accepted.
- R9: Fault priority is invalid selector, then privilege, then limit. Any faulted result drives `out_lin` to zero, and a clean result has fault code 00.
- R10: A request accepted on a clock edge appears with `out_valid` high after that edge. The result holds steady while `out_ready` is low. `in_ready` is high exactly when the output stage is empty or is being drained.
- R11: After reset, `out_valid` is low, `in_ready` is high, and every descriptor entry reads as never written.
- R12: A descriptor write updates only the entry in the table it names. An entry with the same index in the other table is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dw_en | input | 1 | Descriptor write strobe |
| dw_tbl | input | 1 | Table written: 0 global, 1 local |
| dw_idx | input | 3 | Entry written |
| dw_base | input | 32 | Segment base to store |
| dw_limit | input | 32 | Segment limit to store |
| dw_dpl | input | 2 | Allowed privilege level to store |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_base_en | input | 1 | Base operand enable |
| in_base | input | 32 | Base register value |
| in_idx_en | input | 1 | Index operand enable |
| in_idx | input | 32 | Index register value |
| in_scale | input | 2 | Scale code |
| in_disp | input | 32 | Displacement |
| in_disp_sz | input | 2 | Displacement size code |
| in_sel | input | 16 | Segment selector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_lin | output | 32 | Linear address (zero on fault) |
| out_fault | output | 2 | Fault code |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, eight entries per table and a 13-bit selector index. With these values, index 8 and index 8191 fall past the populated range, and a 32-bit base near the top of the address space shows the wrap. Six global and four local entries are written with mixed limits and allowed levels. Random selectors therefore reach every fault class, and the priority cases where several faults overlap, under random back-pressure.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_AW = 32;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_BADSEL = 2'b01,
    FLT_PRIV   = 2'b10,
    FLT_LIMIT  = 2'b11
  } seg_fault_e;

  typedef struct packed {
    logic [SEG_AW-1:0] base;
    logic [SEG_AW-1:0] limit;
    logic [1:0]        dpl;
  } seg_desc_t;
endpackage

// File: rtl/ea_offset_calc.sv
module ea_offset_calc #(
  parameter int AW = 32
) (
  input  logic          base_en,
  input  logic [AW-1:0] base_val,
  input  logic          idx_en,
  input  logic [AW-1:0] idx_val,
  input  logic [1:0]    scale,
  input  logic [AW-1:0] disp,
  input  logic [1:0]    disp_sz,
  output logic [AW-1:0] offset
);
  logic [AW-1:0] base_term, idx_term, disp_term;

  always_comb begin
    base_term = base_en ? base_val : '0;
    idx_term  = idx_en ? (idx_val << scale) : '0;
    case (disp_sz)
      2'b00:   disp_term = '0;
      2'b01:   disp_term = {{(AW-8){disp[7]}}, disp[7:0]};
      default: disp_term = disp;
    endcase
    offset = base_term + idx_term + disp_term;
  end
endmodule

// File: rtl/desc_cache.sv
module desc_cache
  import seg_addr_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_tbl,
  input  logic [IW-1:0] wr_idx,
  input  seg_desc_t     wr_desc,
  input  logic          rd_tbl,
  input  logic [IW-1:0] rd_idx,
  output seg_desc_t     rd_desc,
  output logic          rd_ok
);
  localparam int TABLES = 2;

  seg_desc_t rd_d [TABLES];
  logic      rd_v [TABLES];

  for (genvar t = 0; t < TABLES; t++) begin : g_tbl
    seg_desc_t         mem [ENTRIES];
    logic [ENTRIES-1:0] vld;
    logic              sel_this;

    assign sel_this = wr_en && (wr_tbl == 1'(t));

    always_ff @(posedge clk) begin
      if (sel_this) mem[wr_idx] <= wr_desc;
    end

    always_ff @(posedge clk) begin
      if (rst)           vld <= '0;
      else if (sel_this) vld[wr_idx] <= 1'b1;
    end

    assign rd_d[t] = mem[rd_idx];
    assign rd_v[t] = vld[rd_idx];

    // R11
    empty_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (vld == '0));
  end

  assign rd_desc = rd_d[rd_tbl];
  assign rd_ok   = rd_v[rd_tbl];
endmodule

// File: rtl/seg_fault_check.sv
module seg_fault_check
  import seg_addr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] offset,
  input  seg_desc_t     desc,
  input  logic          sel_ok,
  input  logic [1:0]    rpl,
  output seg_fault_e    fault,
  output logic [AW-1:0] lin
);
  always_comb begin
    if (!sel_ok)                fault = FLT_BADSEL;
    else if (rpl > desc.dpl)    fault = FLT_PRIV;
    else if (offset > desc.limit) fault = FLT_LIMIT;
    else                        fault = FLT_NONE;
    lin = (fault == FLT_NONE) ? (desc.base + offset) : '0;
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int AW      = 32,
  parameter int ENTRIES = 8,
  parameter int SELW    = 13,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dw_en,
  input  logic          dw_tbl,
  input  logic [IW-1:0] dw_idx,
  input  logic [AW-1:0] dw_base,
  input  logic [AW-1:0] dw_limit,
  input  logic [1:0]    dw_dpl,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_base_en,
  input  logic [AW-1:0] in_base,
  input  logic          in_idx_en,
  input  logic [AW-1:0] in_idx,
  input  logic [1:0]    in_scale,
  input  logic [AW-1:0] in_disp,
  input  logic [1:0]    in_disp_sz,
  input  logic [SELW+2:0] in_sel,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_lin,
  output logic [1:0]    out_fault
);
  localparam logic [SELW-1:0] ENT_LIM = SELW'(ENTRIES);

  logic [SELW-1:0] sel_idx;
  logic            sel_tbl;
  logic [1:0]      sel_rpl;
  logic            in_range;
  logic [AW-1:0]   offset;
  seg_desc_t       wr_desc, rd_desc;
  logic            rd_ok;
  seg_fault_e      fault;
  logic [AW-1:0]   lin;

  assign sel_idx  = in_sel[SELW+2:3];
  assign sel_tbl  = in_sel[2];
  assign sel_rpl  = in_sel[1:0];
  assign in_range = sel_idx < ENT_LIM;

  assign wr_desc = '{base: dw_base, limit: dw_limit, dpl: dw_dpl};

  ea_offset_calc #(.AW(AW)) u_ofs (
    .base_en (in_base_en),
    .base_val(in_base),
    .idx_en  (in_idx_en),
    .idx_val (in_idx),
    .scale   (in_scale),
    .disp    (in_disp),
    .disp_sz (in_disp_sz),
    .offset  (offset)
  );

  desc_cache #(.ENTRIES(ENTRIES)) u_cache (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (dw_en),
    .wr_tbl (dw_tbl),
    .wr_idx (dw_idx),
    .wr_desc(wr_desc),
    .rd_tbl (sel_tbl),
    .rd_idx (sel_idx[IW-1:0]),
    .rd_desc(rd_desc),
    .rd_ok  (rd_ok)
  );

  seg_fault_check #(.AW(AW)) u_chk (
    .offset(offset),
    .desc  (rd_desc),
    .sel_ok(in_range && rd_ok),
    .rpl   (sel_rpl),
    .fault (fault),
    .lin   (lin)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_lin   <= '0;
      out_fault <= FLT_NONE;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_lin   <= lin;
        out_fault <= fault;
      end
    end
  end

  // R10
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lin) && $stable(out_fault)));

  // R10
  valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R9
  fault_zero_lin_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault != FLT_NONE) |-> (out_lin == '0));
endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
  localparam int AW = 32;
  localparam int ENT = 8;
  localparam int SELW = 13;

  typedef struct {
    logic [31:0] lin;
    logic [1:0]  flt;
    string       tag;
  } exp_t;

  logic clk = 0, rst = 1;
  logic dw_en = 0, dw_tbl = 0;
  logic [2:0] dw_idx = 0;
  logic [31:0] dw_base = 0, dw_limit = 0;
  logic [1:0] dw_dpl = 0;
  logic in_valid = 0, in_ready;
  logic in_base_en = 0, in_idx_en = 0;
  logic [31:0] in_base = 0, in_idx = 0, in_disp = 0;
  logic [1:0] in_scale = 0, in_disp_sz = 0;
  logic [15:0] in_sel = 0;
  logic out_valid, out_ready = 1;
  logic [31:0] out_lin;
  logic [1:0] out_fault;

  always #10 clk = ~clk;

  seg_addr_gen uut (
    .clk(clk), .rst(rst), .dw_en(dw_en), .dw_tbl(dw_tbl), .dw_idx(dw_idx),
    .dw_base(dw_base), .dw_limit(dw_limit), .dw_dpl(dw_dpl),
    .in_valid(in_valid), .in_ready(in_ready), .in_base_en(in_base_en),
    .in_base(in_base), .in_idx_en(in_idx_en), .in_idx(in_idx),
    .in_scale(in_scale), .in_disp(in_disp), .in_disp_sz(in_disp_sz),
    .in_sel(in_sel), .out_valid(out_valid), .out_ready(out_ready),
    .out_lin(out_lin), .out_fault(out_fault)
  );

  int checks = 0, fails = 0;
  string cur_tag = "R1";
  bit acc_last;
  exp_t q[$];
  logic [31:0] m_base [2][ENT];
  logic [31:0] m_lim  [2][ENT];
  logic [1:0]  m_dpl  [2][ENT];
  bit          m_vld  [2][ENT];

  function automatic logic [15:0] mksel(int idx, int tbl, int rpl);
    return 16'((idx << 3) | (tbl << 2) | rpl);
  endfunction

  function automatic exp_t calc();
    exp_t e;
    logic [31:0] d, ofs;
    int idx, tbl, rpl;
    idx = int'(in_sel[15:3]); tbl = int'(in_sel[2]); rpl = int'(in_sel[1:0]);
    if (in_disp_sz == 2'b00)      d = 0;
    else if (in_disp_sz == 2'b01) d = 32'($signed(in_disp[7:0]));
    else                          d = in_disp;
    ofs = (in_base_en ? in_base : 32'd0) + (in_idx_en ? in_idx * (32'd1 << in_scale) : 32'd0) + d;
    if (idx >= ENT || !m_vld[tbl][idx]) e.flt = 2'b01;
    else if (rpl > int'(m_dpl[tbl][idx])) e.flt = 2'b10;
    else if (ofs > m_lim[tbl][idx]) e.flt = 2'b11;
    else e.flt = 2'b00;
    e.lin = (e.flt == 2'b00) ? m_base[tbl][idx] + ofs : 32'd0;
    e.tag = cur_tag;
    return e;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    bit acc, pop, wr;
    exp_t e;
    #1;
    acc = in_valid && in_ready;
    pop = out_valid && out_ready;
    wr = dw_en;
    chk(in_ready == (q.size() == 0 || out_ready), "R10", "in_ready", 32'(in_ready), 32'(q.size() == 0 || out_ready));
    if (acc) e = calc();
    @(negedge clk);
    if (pop) void'(q.pop_front());
    if (acc) q.push_back(e);
    if (wr) begin
      m_base[dw_tbl][dw_idx] = dw_base; m_lim[dw_tbl][dw_idx] = dw_limit;
      m_dpl[dw_tbl][dw_idx] = dw_dpl;   m_vld[dw_tbl][dw_idx] = 1;
    end
    acc_last = acc;
    #1;
    chk(out_valid == (q.size() != 0), "R10", "out_valid", 32'(out_valid), 32'(q.size() != 0));
    if (q.size() != 0 && out_valid) begin
      chk(out_fault == q[0].flt, q[0].tag, "fault", 32'(out_fault), 32'(q[0].flt));
      chk(out_lin == q[0].lin, q[0].tag, "linear", out_lin, q[0].lin);
    end
  endtask

  task automatic wr_desc(int tbl, int idx, logic [31:0] b, logic [31:0] l, int dpl);
    dw_en = 1; dw_tbl = 1'(tbl); dw_idx = 3'(idx); dw_base = b; dw_limit = l; dw_dpl = 2'(dpl);
    tick();
    dw_en = 0;
  endtask

  task automatic txn(bit be, logic [31:0] b, bit ie, logic [31:0] i, int sc,
                     logic [31:0] d, int dsz, logic [15:0] sel);
    in_base_en = be; in_base = b; in_idx_en = ie; in_idx = i; in_scale = 2'(sc);
    in_disp = d; in_disp_sz = 2'(dsz); in_sel = sel; in_valid = 1;
    do tick(); while (!acc_last);
    in_valid = 0;
    while (q.size() != 0) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < 2; t++)
      for (int k = 0; k < ENT; k++) begin
        m_vld[t][k] = 0; m_base[t][k] = 0; m_lim[t][k] = 0; m_dpl[t][k] = 0;
      end
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R11 reset state
    chk(out_valid == 0, "R11", "out_valid after reset", 32'(out_valid), 0);
    chk(in_ready == 1, "R11", "in_ready after reset", 32'(in_ready), 1);
    cur_tag = "R11";
    txn(0, 0, 0, 0, 0, 32'h10, 2, mksel(0, 0, 0));

    for (int k = 0; k < 6; k++)
      wr_desc(0, k, 32'h1000_0000 * k + 32'h100, (k < 4) ? 32'hFFFF_FFFF : 32'h0000_0FFF, k % 4);
    for (int k = 0; k < 4; k++)
      wr_desc(1, k, 32'h8000_0000 + 32'h10 * k, 32'h1FF, 3);

    cur_tag = "R1";
    txn(1, 32'h1234, 1, 32'h10, 0, 32'h0005_0000, 2, mksel(3, 0, 0));
    txn(1, 32'hFFFF_FFF0, 0, 0, 0, 32'h20, 2, mksel(3, 0, 3));
    cur_tag = "R2";
    for (int s = 0; s < 4; s++) txn(0, 0, 1, 32'h11, s, 0, 0, mksel(2, 0, 1));
    cur_tag = "R3";
    txn(1, 32'h100, 0, 0, 0, 32'hFFFF_FF80, 1, mksel(3, 0, 0));
    txn(1, 32'h100, 0, 0, 0, 32'h1234_567F, 1, mksel(3, 0, 0));
    txn(1, 32'h100, 0, 0, 0, 32'hDEAD_BEEF, 0, mksel(3, 0, 0));
    txn(1, 32'h100, 0, 0, 0, 32'h0000_0180, 2, mksel(3, 0, 0));
    txn(1, 32'h100, 0, 0, 0, 32'h0000_0180, 3, mksel(3, 0, 0));
    cur_tag = "R4";
    txn(1, 32'h40, 0, 32'hFFFF, 3, 32'h77, 0, mksel(1, 0, 1));
    txn(0, 32'hFFFF, 1, 32'h40, 1, 32'h77, 0, mksel(1, 0, 1));
    txn(0, 32'hFFFF, 0, 32'hFFFF, 1, 32'h77, 2, mksel(1, 0, 1));
    cur_tag = "R5";
    txn(1, 32'h20, 0, 0, 0, 0, 0, mksel(1, 0, 1));
    txn(1, 32'h20, 0, 0, 0, 0, 0, mksel(1, 1, 3));
    cur_tag = "R6";
    txn(1, 32'h20, 0, 0, 0, 0, 0, mksel(8, 0, 0));
    txn(1, 32'h20, 0, 0, 0, 0, 0, mksel(6, 0, 0));
    txn(1, 32'h20, 0, 0, 0, 0, 0, mksel(5, 1, 0));
    txn(1, 32'h20, 0, 0, 0, 0, 0, mksel(8191, 1, 0));
    cur_tag = "R7";
    txn(1, 32'h20, 0, 0, 0, 0, 0, mksel(0, 0, 1));
    txn(1, 32'h20, 0, 0, 0, 0, 0, mksel(0, 0, 0));
    cur_tag = "R8";
    txn(1, 32'hFFF, 0, 0, 0, 0, 0, mksel(4, 0, 0));
    txn(1, 32'hFFF, 0, 0, 0, 1, 1, mksel(4, 0, 0));
    cur_tag = "R9";
    txn(1, 32'h2000, 0, 0, 0, 0, 0, mksel(4, 0, 1));
    txn(1, 32'h2000, 0, 0, 0, 0, 0, mksel(9, 0, 3));
    cur_tag = "R12";
    wr_desc(1, 2, 32'hA000_0000, 32'hFFFF, 3);
    txn(1, 32'h8, 0, 0, 0, 0, 0, mksel(2, 0, 2));
    txn(1, 32'h8, 0, 0, 0, 0, 0, mksel(2, 1, 2));

    cur_tag = "R10";
    in_valid = 1; out_ready = 0; in_base_en = 1; in_base = 32'h30; in_sel = mksel(3, 0, 0);
    in_disp_sz = 0; in_idx_en = 0;
    repeat (4) tick();
    out_ready = 1; in_valid = 0;
    repeat (3) tick();

    cur_tag = "R1";
    for (int n = 0; n < 600; n++) begin
      in_valid   = ($urandom % 4) != 0;
      out_ready  = ($urandom % 4) != 0;
      in_base_en = $urandom % 2; in_idx_en = $urandom % 2;
      in_base    = ($urandom % 2) ? $urandom : ($urandom % 32'h1000);
      in_idx     = ($urandom % 2) ? $urandom : ($urandom % 32'h100);
      in_scale   = 2'($urandom); in_disp = $urandom; in_disp_sz = 2'($urandom);
      in_sel     = mksel($urandom % 10, $urandom % 2, $urandom % 4);
      tick();
    end
    in_valid = 0; out_ready = 1;
    repeat (3) tick();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule